// File: doc/BRIEF.md
# Event Counter with Shared-Prescaler Watchdog

This block pairs an 8-bit event counter with an 8-bit watchdog. One prescaler serves both of them. The event counter advances on one of two sources. The first is an instruction-cycle enable. The second is an edge on an asynchronous input pin, with the edge polarity selectable. When the counter wraps from its top value to zero, it sets a sticky overflow flag. That flag can raise an interrupt through an active-low enable.

The watchdog counts ticks of a slow timebase, and it keeps counting in power down. One configuration bit assigns the prescaler to either the counter or the watchdog. The other user counts undivided. On expiry the watchdog does one of two things. If the device is active, it pulses a reset request. If the device is powered down, it pulses a wakeup. Two status bits, timeout and power-down, record the cause of the last reset and the power state.

All the pins are plain control and status pins. No data stream crosses the boundary, so the block has no valid/ready handshake.

Top module: `evt_watch`

## Requirements
- R1: With `src_ext`=0 the counter advances once per cycle in which `cyc_tick` is high. With `src_ext`=1 it ignores `cyc_tick` and advances once per transition of `cnt_pin`. A value of 1 on `edge_fall` selects high-to-low transitions, and 0 selects low-to-high. The pin passes through a two-flop synchronizer, so a transition shows on `cnt_val` three clock edges after it occurs.
- R2: When `psc_to_wd`=0 the prescaler belongs to the counter, which advances once every 2^(`psc_sel`+1) source events. When `psc_to_wd`=1 the counter advances on every source event.
- R3: A wrap of `cnt_val` from 8'hFF to 8'h00 sets `ovf_flag`. The flag stays set until `ovf_clr` is pulsed, and a wrap in the same cycle as `ovf_clr` wins.
- R4: `irq` is high exactly when `ovf_flag` is 1 and `irq_en_n` is 0.
- R5: While `wd_en`=1, the watchdog counts `wd_tick` cycles. When `psc_to_wd`=1 it counts once per 2^`psc_sel` ticks, and otherwise once per tick. It expires on its 256th count.
- R6: An expiry while active pulses `wd_rst` high for one cycle and writes {`to_bit`,`pd_bit`} = 01. It also clears `cnt_val` and `ovf_flag`. `wd_rst` and `wd_wake` are never high together.
- R7: An expiry while powered down pulses `wd_wake` for one cycle and clears `pwr_down`. It writes {`to_bit`,`pd_bit`} = 00 and leaves `cnt_val` unchanged.
- R8: A pulse on `wd_clr` zeroes the watchdog and the prescaler, and it sets `to_bit` and `pd_bit` to 1.
- R9: A pulse on `sleep_req` sets `pwr_down`, writes {`to_bit`,`pd_bit`} = 10, and zeroes the watchdog and the prescaler.
- R10: A pulse on `ext_rst` clears the counter, the flag, the watchdog and the prescaler, and it clears `pwr_down`. If the block was powered down, it writes {`to_bit`,`pd_bit`} = 10. If the block was active, it leaves both status bits unchanged. Within one cycle the priority is `ext_rst`, then `wd_clr`, then `sleep_req`, then expiry.
- R11: After `rst_n`, `cnt_val`=0, `ovf_flag`=0, `pwr_down`=0, `wd_rst`=`wd_wake`=0 and {`to_bit`,`pd_bit`} = 11.
- R12: Any change of `psc_to_wd` clears the prescaler, so no partial count carries across a reassignment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| cyc_tick | input | 1 | Instruction-cycle count enable |
| cnt_pin | input | 1 | Asynchronous external count input |
| edge_fall | input | 1 | 1 counts falling edges of cnt_pin, 0 counts rising edges |
| src_ext | input | 1 | 1 selects cnt_pin as the source, 0 selects cyc_tick |
| psc_to_wd | input | 1 | 1 assigns the prescaler to the watchdog, 0 assigns it to the counter |
| psc_sel | input | 3 | Prescaler divide exponent |
| irq_en_n | input | 1 | Overflow interrupt enable, active low |
| wd_en | input | 1 | Watchdog enable |
| wd_tick | input | 1 | Watchdog timebase enable |
| wd_clr | input | 1 | Clear-watchdog command pulse |
| sleep_req | input | 1 | Enter power down pulse |
| ext_rst | input | 1 | External reset event pulse |
| ovf_clr | input | 1 | Clears the overflow flag |
| cnt_val | output | 8 | Event counter value |
| ovf_flag | output | 1 | Sticky overflow flag |
| irq | output | 1 | Overflow interrupt |
| wd_rst | output | 1 | One-cycle watchdog reset request |
| wd_wake | output | 1 | One-cycle watchdog wakeup |
| pwr_down | output | 1 | Power-down state |
| to_bit | output | 1 | Timeout status bit |
| pd_bit | output | 1 | Power-down status bit |

## Verification
The assertions take for granted that `ext_rst`, `wd_clr` and `sleep_req` are held low while `rst_n` is asserted. The counter-step and wrap properties also assume that every clear of `cnt_val` comes from `ext_rst` or from a watchdog reset. The stimulus drives every input on the falling clock edge. It holds each level of `cnt_pin` for at least two cycles, so every transition survives synchronization. Before any window whose expected count the bench computes, it pulses `ext_rst` or `wd_clr`, which restarts the prescaler and the watchdog from zero.

// File: rtl/evt_watch_pkg.sv
package evt_watch_pkg;

  // Reset-cause status pair
  typedef struct packed {
    logic to;
    logic pd;
  } rst_stat_t;

  localparam rst_stat_t STAT_POR     = '{to: 1'b1, pd: 1'b1};
  localparam rst_stat_t STAT_WD_ACT  = '{to: 1'b0, pd: 1'b1};
  localparam rst_stat_t STAT_WD_SLP  = '{to: 1'b0, pd: 1'b0};
  localparam rst_stat_t STAT_SLEEP   = '{to: 1'b1, pd: 1'b0};
  localparam rst_stat_t STAT_XRST_PD = '{to: 1'b1, pd: 1'b0};

endpackage

// File: rtl/evt_watch_edge.sv
module evt_watch_edge #(
  parameter int SYNC_N = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  input  logic fall_sel,
  output logic hit
);
  // stages 0..SYNC_N-1 synchronize, stage SYNC_N holds the previous level
  logic [SYNC_N:0] stg;

  for (genvar i = 0; i <= SYNC_N; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[0] <= 1'b0;
        else        stg[0] <= pin;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[i] <= 1'b0;
        else        stg[i] <= stg[i-1];
      end
    end
  end

  logic rise, fall;
  assign rise = stg[SYNC_N-1] & ~stg[SYNC_N];
  assign fall = ~stg[SYNC_N-1] & stg[SYNC_N];
  assign hit  = fall_sel ? fall : rise;
endmodule

// File: rtl/evt_watch_psc.sv
module evt_watch_psc #(
  parameter int PS_W  = 8,
  parameter int SEL_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             ev,
  input  logic             to_wd,
  input  logic [SEL_W-1:0] sel,
  output logic             carry
);
  localparam int EXP_W = SEL_W + 1;

  logic [PS_W-1:0]  psc_q;
  logic [EXP_W-1:0] dexp;
  logic [PS_W:0]    span;
  logic [PS_W-1:0]  mask;

  // watchdog divides by 2^sel, counter by 2^(sel+1)
  always_comb begin
    dexp  = to_wd ? {1'b0, sel} : ({1'b0, sel} + EXP_W'(1));
    span  = (PS_W+1)'(1) << dexp;
    mask  = PS_W'(span - (PS_W+1)'(1));
    carry = ev && ((psc_q & mask) == mask);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   psc_q <= '0;
    else if (clr) psc_q <= '0;
    else if (ev)  psc_q <= psc_q + PS_W'(1);
  end
endmodule

// File: rtl/evt_watch_wdog.sv
module evt_watch_wdog
  import evt_watch_pkg::*;
#(
  parameter int WD_W = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic inc,
  input  logic ext_rst,
  input  logic wd_clr,
  input  logic sleep_req,
  output logic expire,
  output logic expire_act,
  output logic wd_rst,
  output logic wd_wake,
  output logic pwr_down,
  output logic to_bit,
  output logic pd_bit
);
  logic [WD_W-1:0] wd_q;
  rst_stat_t       stat_q;
  logic            cmd_any;

  assign cmd_any    = ext_rst | wd_clr | sleep_req;
  assign expire     = inc && (wd_q == {WD_W{1'b1}}) && !cmd_any;
  assign expire_act = expire && !pwr_down;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       wd_q <= '0;
    else if (cmd_any) wd_q <= '0;
    else if (inc)     wd_q <= wd_q + WD_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q   <= STAT_POR;
      pwr_down <= 1'b0;
      wd_rst   <= 1'b0;
      wd_wake  <= 1'b0;
    end else begin
      wd_rst  <= 1'b0;
      wd_wake <= 1'b0;
      if (ext_rst) begin
        if (pwr_down) stat_q <= STAT_XRST_PD;
        pwr_down <= 1'b0;
      end else if (wd_clr) begin
        stat_q <= STAT_POR;
      end else if (sleep_req) begin
        stat_q   <= STAT_SLEEP;
        pwr_down <= 1'b1;
      end else if (expire) begin
        if (pwr_down) begin
          stat_q   <= STAT_WD_SLP;
          pwr_down <= 1'b0;
          wd_wake  <= 1'b1;
        end else begin
          stat_q <= STAT_WD_ACT;
          wd_rst <= 1'b1;
        end
      end
    end
  end

  assign to_bit = stat_q.to;
  assign pd_bit = stat_q.pd;
endmodule

// File: rtl/evt_watch.sv
module evt_watch #(
  parameter int CNT_W  = 8,
  parameter int WD_W   = 8,
  parameter int PS_W   = 8,
  parameter int SEL_W  = 3,
  parameter int SYNC_N = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cyc_tick,
  input  logic             cnt_pin,
  input  logic             edge_fall,
  input  logic             src_ext,
  input  logic             psc_to_wd,
  input  logic [SEL_W-1:0] psc_sel,
  input  logic             irq_en_n,
  input  logic             wd_en,
  input  logic             wd_tick,
  input  logic             wd_clr,
  input  logic             sleep_req,
  input  logic             ext_rst,
  input  logic             ovf_clr,
  output logic [CNT_W-1:0] cnt_val,
  output logic             ovf_flag,
  output logic             irq,
  output logic             wd_rst,
  output logic             wd_wake,
  output logic             pwr_down,
  output logic             to_bit,
  output logic             pd_bit
);
  logic pin_hit, src_ev, psc_ev, psc_carry, psc_clr;
  logic assign_q, assign_chg;
  logic cnt_inc, wd_inc, expire, expire_act, soft_clr;

  evt_watch_edge #(.SYNC_N(SYNC_N)) u_edge (
    .clk(clk), .rst_n(rst_n), .pin(cnt_pin), .fall_sel(edge_fall), .hit(pin_hit)
  );

  assign src_ev = src_ext ? pin_hit : cyc_tick;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) assign_q <= 1'b0;
    else        assign_q <= psc_to_wd;
  end
  assign assign_chg = psc_to_wd ^ assign_q;

  assign psc_ev  = psc_to_wd ? wd_tick : src_ev;
  assign psc_clr = assign_chg | ext_rst | wd_clr | sleep_req | expire;

  evt_watch_psc #(.PS_W(PS_W), .SEL_W(SEL_W)) u_psc (
    .clk(clk), .rst_n(rst_n), .clr(psc_clr), .ev(psc_ev),
    .to_wd(psc_to_wd), .sel(psc_sel), .carry(psc_carry)
  );

  assign cnt_inc = psc_to_wd ? src_ev : (psc_carry & ~assign_chg);
  assign wd_inc  = wd_en & (psc_to_wd ? (psc_carry & ~assign_chg) : wd_tick);

  evt_watch_wdog #(.WD_W(WD_W)) u_wdog (
    .clk(clk), .rst_n(rst_n), .inc(wd_inc), .ext_rst(ext_rst), .wd_clr(wd_clr),
    .sleep_req(sleep_req), .expire(expire), .expire_act(expire_act),
    .wd_rst(wd_rst), .wd_wake(wd_wake), .pwr_down(pwr_down),
    .to_bit(to_bit), .pd_bit(pd_bit)
  );

  assign soft_clr = ext_rst | expire_act;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_val  <= '0;
      ovf_flag <= 1'b0;
    end else if (soft_clr) begin
      cnt_val  <= '0;
      ovf_flag <= 1'b0;
    end else begin
      if (cnt_inc) cnt_val <= cnt_val + CNT_W'(1);
      if (cnt_inc && (cnt_val == {CNT_W{1'b1}})) ovf_flag <= 1'b1;
      else if (ovf_clr)                          ovf_flag <= 1'b0;
    end
  end

  assign irq = ovf_flag & ~irq_en_n;
endmodule

// File: rtl/evt_watch_chk.sv
module evt_watch_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ext_rst,
  input logic             wd_clr,
  input logic             sleep_req,
  input logic [CNT_W-1:0] cnt_val,
  input logic             ovf_flag,
  input logic             wd_rst,
  input logic             wd_wake,
  input logic             pwr_down,
  input logic             to_bit,
  input logic             pd_bit
);
  // R1: the counter only steps by one unless a reset source cleared it
  p_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(ext_rst) && !wd_rst && cnt_val != $past(cnt_val))
      |-> cnt_val == $past(cnt_val) + CNT_W'(1));

  // R3: a natural wrap always leaves the flag set
  p_wrap_flag_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(cnt_val) == {CNT_W{1'b1}} && cnt_val == '0 && !$past(ext_rst) && !wd_rst)
      |-> ovf_flag);

  // R6: reset request carries status 01, never with a wakeup
  p_rst_stat_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wd_rst |-> (!to_bit && pd_bit));
  p_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(wd_rst && wd_wake));

  // R7: wakeup leaves power down with status 00
  p_wake_stat_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wd_wake |-> (!to_bit && !pd_bit && !pwr_down));

  // R8: clear-watchdog sets both status bits
  p_clr_stat_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(wd_clr) && !$past(ext_rst)) |-> (to_bit && pd_bit));

  // R9: sleep request enters power down with status 10
  p_sleep_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(sleep_req) && !$past(ext_rst) && !$past(wd_clr))
      |-> (pwr_down && to_bit && !pd_bit));

  // R10: external reset while active keeps status
  p_xrst_keep_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(ext_rst) && !$past(pwr_down))
      |-> (to_bit == $past(to_bit) && pd_bit == $past(pd_bit)));
endmodule

bind evt_watch evt_watch_chk #(.CNT_W(CNT_W)) u_evt_watch_chk (
  .clk(clk), .rst_n(rst_n), .ext_rst(ext_rst), .wd_clr(wd_clr),
  .sleep_req(sleep_req), .cnt_val(cnt_val), .ovf_flag(ovf_flag),
  .wd_rst(wd_rst), .wd_wake(wd_wake), .pwr_down(pwr_down),
  .to_bit(to_bit), .pd_bit(pd_bit)
);

// File: tb/test_evt_watch.sv
module test_evt_watch;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cyc_tick = 0, cnt_pin = 0, edge_fall = 0, src_ext = 0;
  logic       psc_to_wd = 0, irq_en_n = 1, wd_en = 0, wd_tick = 0;
  logic       wd_clr = 0, sleep_req = 0, ext_rst = 0, ovf_clr = 0;
  logic [2:0] psc_sel = 3'd0;
  logic [7:0] cnt_val;
  logic       ovf_flag, irq, wd_rst, wd_wake, pwr_down, to_bit, pd_bit;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  evt_watch i_evt_watch (
    .clk(clk), .rst_n(rst_n), .cyc_tick(cyc_tick), .cnt_pin(cnt_pin),
    .edge_fall(edge_fall), .src_ext(src_ext), .psc_to_wd(psc_to_wd),
    .psc_sel(psc_sel), .irq_en_n(irq_en_n), .wd_en(wd_en), .wd_tick(wd_tick),
    .wd_clr(wd_clr), .sleep_req(sleep_req), .ext_rst(ext_rst), .ovf_clr(ovf_clr),
    .cnt_val(cnt_val), .ovf_flag(ovf_flag), .irq(irq), .wd_rst(wd_rst),
    .wd_wake(wd_wake), .pwr_down(pwr_down), .to_bit(to_bit), .pd_bit(pd_bit)
  );

  // expected counter value after n source events from a cleared prescaler
  function automatic int exp_cnt(int n, int sel, bit psc_on_cnt);
    int k = psc_on_cnt ? (n >> (sel + 1)) : n;
    return k % 256;
  endfunction

  function automatic bit exp_ovf(int n, int sel, bit psc_on_cnt);
    int k = psc_on_cnt ? (n >> (sel + 1)) : n;
    return k >= 256;
  endfunction

  task automatic chk(string req, int got, int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic hold_tick(int n);
    if (n > 0) begin
      @(negedge clk) cyc_tick = 1;
      repeat (n) @(negedge clk);
      cyc_tick = 0;
    end
  endtask

  task automatic hold_wd(int n);
    if (n > 0) begin
      @(negedge clk) wd_tick = 1;
      repeat (n) @(negedge clk);
      wd_tick = 0;
    end
  endtask

  task automatic toggle_pin(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) cnt_pin = ~cnt_pin;
      repeat (2) @(negedge clk);
    end
    repeat (4) @(negedge clk);
  endtask

  task automatic do_xrst();
    @(negedge clk) ext_rst = 1;
    @(negedge clk) ext_rst = 0;
  endtask

  task automatic do_clr();
    @(negedge clk) wd_clr = 1;
    @(negedge clk) wd_clr = 0;
  endtask

  task automatic do_sleep();
    @(negedge clk) sleep_req = 1;
    @(negedge clk) sleep_req = 0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog timer expired");
    finish_run();
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R11 reset state
    chk("R11 cnt", cnt_val, 0);
    chk("R11 ovf", ovf_flag, 0);
    chk("R11 pwr_down", pwr_down, 0);
    chk("R11 wd_rst", wd_rst, 0);
    chk("R11 status", {to_bit, pd_bit}, 2'b11);

    // R1 internal source, undivided
    @(negedge clk) psc_to_wd = 1;
    hold_tick(37);
    chk("R1 internal count", cnt_val, 37);

    // R2 prescaler on counter, divide by 8
    @(negedge clk) begin psc_to_wd = 0; psc_sel = 3'd2; end
    do_xrst();
    hold_tick(40);
    chk("R2 divided count", cnt_val, exp_cnt(40, 2, 1));

    // R12 reassignment drops the partial count
    hold_tick(5);
    @(negedge clk) psc_to_wd = 1;
    @(negedge clk) psc_to_wd = 0;
    hold_tick(3);
    chk("R12 partial count dropped", cnt_val, 5);
    hold_tick(5);
    chk("R12 fresh prescale", cnt_val, 6);

    // R1 external pin, both polarities
    @(negedge clk) begin psc_to_wd = 1; src_ext = 1; edge_fall = 0; end
    do_xrst();
    hold_tick(10);
    chk("R1 cyc_tick ignored on pin source", cnt_val, 0);
    toggle_pin(10);
    chk("R1 rising edges", cnt_val, 5);
    @(negedge clk) edge_fall = 1;
    toggle_pin(6);
    chk("R1 falling edges", cnt_val, 8);
    @(negedge clk) src_ext = 0;

    // R3 and R4 overflow and interrupt
    do_xrst();
    hold_tick(255);
    chk("R3 no flag before wrap", ovf_flag, 0);
    chk("R3 top value", cnt_val, 255);
    hold_tick(1);
    chk("R3 wrap value", cnt_val, 0);
    chk("R3 flag set", ovf_flag, 1);
    #1;
    chk("R4 irq masked", irq, 0);
    @(negedge clk) irq_en_n = 0;
    #1;
    chk("R4 irq enabled", irq, 1);
    hold_tick(3);
    chk("R3 flag sticky", ovf_flag, 1);
    @(negedge clk) ovf_clr = 1;
    @(negedge clk) ovf_clr = 0;
    chk("R3 flag cleared", ovf_flag, 0);
    chk("R4 irq follows flag", irq, 0);

    // R5 and R6 watchdog undivided, expiry while active
    @(negedge clk) begin psc_to_wd = 0; psc_sel = 3'd2; wd_en = 1; end
    do_xrst();
    do_clr();
    chk("R8 status after clear", {to_bit, pd_bit}, 2'b11);
    hold_tick(32);
    chk("R2 count before expiry", cnt_val, 4);
    hold_wd(255);
    chk("R5 no expiry at 255", wd_rst, 0);
    hold_wd(1);
    chk("R6 reset pulse", wd_rst, 1);
    chk("R6 status 01", {to_bit, pd_bit}, 2'b01);
    chk("R6 counter cleared", cnt_val, 0);
    @(negedge clk);
    chk("R6 pulse is one cycle", wd_rst, 0);
    do_xrst();
    chk("R10 active ext reset keeps status", {to_bit, pd_bit}, 2'b01);

    // R5 prescaler on watchdog, divide by 2
    @(negedge clk) begin psc_to_wd = 1; psc_sel = 3'd1; end
    do_clr();
    hold_wd(511);
    chk("R5 no expiry at 511 ticks", wd_rst, 0);
    hold_wd(1);
    chk("R5 prescaled expiry", wd_rst, 1);

    // R9 and R7 sleep, then wake by watchdog
    @(negedge clk) psc_to_wd = 0;
    hold_tick(16);
    chk("R2 divide by 4", cnt_val, 4);
    do_sleep();
    chk("R9 power down", pwr_down, 1);
    chk("R9 status 10", {to_bit, pd_bit}, 2'b10);
    hold_wd(256);
    chk("R7 wake pulse", wd_wake, 1);
    chk("R7 no reset pulse", wd_rst, 0);
    chk("R7 awake", pwr_down, 0);
    chk("R7 status 00", {to_bit, pd_bit}, 2'b00);
    chk("R7 counter kept", cnt_val, 4);

    // R10 external reset while powered down
    do_sleep();
    do_xrst();
    chk("R10 status 10", {to_bit, pd_bit}, 2'b10);
    chk("R10 leaves power down", pwr_down, 0);
    chk("R10 counter cleared", cnt_val, 0);

    // R8 clear restarts the watchdog window
    hold_wd(200);
    do_clr();
    hold_wd(200);
    chk("R8 window restarted", wd_rst, 0);
    chk("R8 status 11", {to_bit, pd_bit}, 2'b11);
    hold_wd(56);
    chk("R8 expiry after full window", wd_rst, 1);

    // R2 and R3 random runs
    @(negedge clk) wd_en = 0;
    for (int it = 0; it < 24; it++) begin
      bit on_cnt = it[0];
      int sel = $urandom % 8;
      int n = $urandom % 600;
      @(negedge clk) begin psc_to_wd = ~on_cnt; psc_sel = 3'(sel); end
      do_xrst();
      hold_tick(n);
      chk("R2 random count", cnt_val, exp_cnt(n, sel, on_cnt));
      chk("R3 random flag", ovf_flag, exp_ovf(n, sel, on_cnt));
    end

    finish_run();
  end
endmodule